// File: doc/BRIEF.md
# Two-Domain Power Mode Sequencer

This block sits in the always-on part of a design that holds two switchable power domains: a serial master and a serial slave. Software or a higher-level controller hands it a requested system mode and the direction of the coming transfer. The block turns each request into per-domain controls: a power-switch enable, a retention save level, an active-low restore and an isolation enable. It drives them in an order that keeps clamped outputs and saved state valid across every transition.

Three system modes exist. In full off both domains are unpowered. In partial on only the master is powered. In full on both are powered. A full-on request for a write-only transfer is reduced to partial on, because the slave only has to drive its return line during reads. The slave is always taken down before the master and brought up after it, so the slave is never powered while the master is off. A request code that would power the slave alone is refused.

Top module: `pwr_mode_seq`

## Requirements
- R1: During reset and right after it, both domains are unpowered: switch enable 0, restore_n 0, save 1, isolation 1; busy and req_err are 0.
- R2: The request code on mode_req selects the target: 2'b00 full off, 2'b01 partial on (master only), 2'b11 full on. In steady state a powered domain shows switch enable 1, restore_n 1, save 0, isolation 0, and an unpowered one shows switch enable 0, restore_n 0, save 1, isolation 1.
- R3: A 2'b11 request with xfer_rd = 0 (write-only) powers only the master, leaving the slave off.
- R4: Power-down order per domain: isolation rises first, save rises one cycle later, and the switch enable and restore_n fall one cycle after that.
- R5: Power-up order per domain: the switch enable rises, restore_n stays low and save high for settle_cycles+1 cycles, then restore_n rises and save falls together, and isolation falls one cycle later.
- R6: The slave domain is switched off before the master goes down and switched on only after the master has finished powering up; the slave switch enable is never 1 while the master switch enable is 0.
- R7: A valid request that arrives while a sequence runs is held and is executed when the sequence ends. A later held request replaces an earlier one.
- R8: busy goes high the cycle after a valid request is sampled and stays high until every domain has reached its target. A request for the current mode gives a short busy window with no change on the domain outputs.
- R9: Request code 2'b10 (slave without master) is rejected. req_err is 1 for exactly the cycle after it is sampled. No domain output changes and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe: mode_req and xfer_rd are valid |
| mode_req | input | 2 | Requested mode: 00 off, 01 partial, 11 full, 10 illegal |
| xfer_rd | input | 1 | 1 when the coming transfer reads from the slave |
| settle_cycles | input | CNT_W | Extra settle cycles after switch-on, before restore |
| busy | output | 1 | Request held or sequence running |
| req_err | output | 1 | Pulse: illegal request rejected |
| mst_pwr_en | output | 1 | Master power switch control, 1 = conducting |
| mst_save | output | 1 | Master retention save, active high |
| mst_restore_n | output | 1 | Master restore, active low |
| mst_iso | output | 1 | Master output isolation to 1, active high |
| slv_pwr_en | output | 1 | Slave power switch control, 1 = conducting |
| slv_save | output | 1 | Slave retention save, active high |
| slv_restore_n | output | 1 | Slave restore, active low |
| slv_iso | output | 1 | Slave output isolation to 1, active high |

## Verification
The bench goes after the transitions where ordering matters. It runs full on to full off, where a design that dropped the master first would power the slave alone. It runs the write-only downgrade, where a naive decoder would leave the slave powered. It uses a zero settle count, where an off-by-one would skip or add a settle cycle and move restore relative to the switch. It sends requests during a sequence, which a design without holding would lose or apply mid-sequence, and it sends an illegal code, which a careless decoder would act on or queue.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        DS_ON      = 3'd0,
        DS_ISO     = 3'd1,
        DS_SAVE    = 3'd2,
        DS_OFF     = 3'd3,
        DS_SETTLE  = 3'd4,
        DS_RESTORE = 3'd5
    } dom_state_e;

    typedef enum logic {
        TS_IDLE = 1'b0,
        TS_RUN  = 1'b1
    } top_state_e;

    localparam logic [1:0] MODE_OFF     = 2'b00;
    localparam logic [1:0] MODE_PARTIAL = 2'b01;
    localparam logic [1:0] MODE_ILLEGAL = 2'b10;
    localparam logic [1:0] MODE_FULL    = 2'b11;

    localparam int NDOM = 2;
    localparam int MST  = 0;
    localparam int SLV  = 1;

endpackage

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_dn,
    input  logic             cmd_up,
    input  logic [CNT_W-1:0] settle,
    output logic             pwr_en,
    output logic             save,
    output logic             restore_n,
    output logic             iso,
    output logic             is_on,
    output logic             is_off
);

    typedef struct packed {
        dom_state_e       st;
        logic [CNT_W-1:0] cnt;
    } dom_regs_t;

    dom_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            DS_ON:      if (cmd_dn) r_d.st = DS_ISO;
            DS_ISO:     r_d.st = DS_SAVE;
            DS_SAVE:    r_d.st = DS_OFF;
            DS_OFF: begin
                if (cmd_up) begin
                    r_d.st  = DS_SETTLE;
                    r_d.cnt = settle;
                end
            end
            DS_SETTLE: begin
                if (r_q.cnt == '0) r_d.st = DS_RESTORE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            DS_RESTORE: r_d.st = DS_ON;
            default:    r_d.st = DS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= DS_OFF;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        pwr_en    = (r_q.st != DS_OFF);
        restore_n = (r_q.st == DS_ON) || (r_q.st == DS_ISO) ||
                    (r_q.st == DS_SAVE) || (r_q.st == DS_RESTORE);
        save      = (r_q.st == DS_SAVE) || (r_q.st == DS_OFF) ||
                    (r_q.st == DS_SETTLE);
        iso       = (r_q.st != DS_ON);
        is_on     = (r_q.st == DS_ON);
        is_off    = (r_q.st == DS_OFF);
    end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       mode_req,
    input  logic             xfer_rd,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic             busy,
    output logic             req_err,
    output logic             mst_pwr_en,
    output logic             mst_save,
    output logic             mst_restore_n,
    output logic             mst_iso,
    output logic             slv_pwr_en,
    output logic             slv_save,
    output logic             slv_restore_n,
    output logic             slv_iso
);

    typedef struct packed {
        top_state_e st;
        logic       pend_v;
        logic       pend_m;
        logic       pend_s;
        logic       tgt_m;
        logic       tgt_s;
        logic       err;
    } top_regs_t;

    top_regs_t r_q, r_d;

    logic [NDOM-1:0] cmd_dn, cmd_up;
    logic [NDOM-1:0] d_pwr, d_save, d_rst_n, d_iso, d_on, d_off;

    generate
        for (genvar g = 0; g < NDOM; g++) begin : g_dom
            pwr_dom_seq #(.CNT_W(CNT_W)) u_dom (
                .clk       (clk),
                .rst_n     (rst_n),
                .cmd_dn    (cmd_dn[g]),
                .cmd_up    (cmd_up[g]),
                .settle    (settle_cycles),
                .pwr_en    (d_pwr[g]),
                .save      (d_save[g]),
                .restore_n (d_rst_n[g]),
                .iso       (d_iso[g]),
                .is_on     (d_on[g]),
                .is_off    (d_off[g])
            );
        end
    endgenerate

    logic req_ok, req_bad, all_stable;

    always_comb begin
        req_bad    = req_valid && (mode_req == MODE_ILLEGAL);
        req_ok     = req_valid && (mode_req != MODE_ILLEGAL);
        all_stable = &(d_on | d_off);
        cmd_dn     = '0;
        cmd_up     = '0;
        r_d        = r_q;
        r_d.err    = req_bad;

        // pending slot: newest legal request wins
        if (req_ok) begin
            r_d.pend_v = 1'b1;
            r_d.pend_m = mode_req[0];
            r_d.pend_s = mode_req[1] & mode_req[0] & xfer_rd;
        end else if ((r_q.st == TS_IDLE) && r_q.pend_v) begin
            r_d.pend_v = 1'b0;
        end

        unique case (r_q.st)
            TS_IDLE: begin
                if (r_q.pend_v) begin
                    r_d.st    = TS_RUN;
                    r_d.tgt_m = r_q.pend_m;
                    r_d.tgt_s = r_q.pend_s;
                end
            end
            TS_RUN: begin
                if (all_stable) begin
                    if (d_on[SLV] && !r_q.tgt_s)      cmd_dn[SLV] = 1'b1;
                    else if (d_on[MST] && !r_q.tgt_m) cmd_dn[MST] = 1'b1;
                    else if (d_off[MST] && r_q.tgt_m) cmd_up[MST] = 1'b1;
                    else if (d_off[SLV] && r_q.tgt_s) cmd_up[SLV] = 1'b1;
                    else                              r_d.st = TS_IDLE;
                end
            end
            default: r_d.st = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= TS_IDLE;
            r_q.pend_v <= 1'b0;
            r_q.pend_m <= 1'b0;
            r_q.pend_s <= 1'b0;
            r_q.tgt_m  <= 1'b0;
            r_q.tgt_s  <= 1'b0;
            r_q.err    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.st == TS_RUN) || r_q.pend_v;
    assign req_err       = r_q.err;
    assign mst_pwr_en    = d_pwr[MST];
    assign mst_save      = d_save[MST];
    assign mst_restore_n = d_rst_n[MST];
    assign mst_iso       = d_iso[MST];
    assign slv_pwr_en    = d_pwr[SLV];
    assign slv_save      = d_save[SLV];
    assign slv_restore_n = d_rst_n[SLV];
    assign slv_iso       = d_iso[SLV];

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       mode_req,
    input logic             xfer_rd,
    input logic [CNT_W-1:0] settle_cycles,
    input logic             busy,
    input logic             req_err,
    input logic             mst_pwr_en,
    input logic             mst_save,
    input logic             mst_restore_n,
    input logic             mst_iso,
    input logic             slv_pwr_en,
    input logic             slv_save,
    input logic             slv_restore_n,
    input logic             slv_iso
);

    a_r4_mst_off_after_save: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_pwr_en && $past(mst_pwr_en)) |-> ($past(mst_iso) && $past(mst_save)));

    a_r4_slv_off_after_save: assert property (@(posedge clk) disable iff (!rst_n)
        (!slv_pwr_en && $past(slv_pwr_en)) |-> ($past(slv_iso) && $past(slv_save)));

    a_r5_mst_restore_powered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_restore_n) |-> (mst_pwr_en && $past(mst_pwr_en)));

    a_r5_slv_restore_powered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_restore_n) |-> (slv_pwr_en && $past(slv_pwr_en)));

    a_r5_mst_iso_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_iso) |-> (mst_restore_n && $past(mst_restore_n)));

    a_r5_slv_iso_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slv_iso) |-> (slv_restore_n && $past(slv_restore_n)));

    a_r6_slave_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        slv_pwr_en |-> mst_pwr_en);

    a_r8_busy_covers_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mst_iso) || !$stable(slv_iso) ||
         !$stable(mst_pwr_en) || !$stable(slv_pwr_en)) |-> busy);

    a_r9_err_from_bad_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> ($past(req_valid) && ($past(mode_req) == 2'b10)));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       mode_req = 2'b00;
    logic             xfer_rd = 1'b0;
    logic [CNT_W-1:0] settle_cycles = 8'd3;
    logic             busy, req_err;
    logic             mst_pwr_en, mst_save, mst_restore_n, mst_iso;
    logic             slv_pwr_en, slv_save, slv_restore_n, slv_iso;

    always #5 clk = ~clk;

    pwr_mode_seq #(.CNT_W(CNT_W)) dut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    // phases: 0 powered, 1 clamping, 2 saving, 3 unpowered, 4 settling, 5 restoring
    int  m_ph[2];
    int  m_tm[2];
    bit  m_run, m_pv, m_pm, m_ps, m_tgm, m_tgs, m_err;

    function automatic bit want_on(input int d);
        return (d == 0) ? m_tgm : m_tgs;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph[0] = 3; m_ph[1] = 3; m_tm[0] = 0; m_tm[1] = 0;
            m_run = 0; m_pv = 0; m_pm = 0; m_ps = 0;
            m_tgm = 0; m_tgs = 0; m_err = 0;
        end else begin
            bit dn[2];
            bit up[2];
            bit finish_run;
            bit quiet;
            dn[0] = 0; dn[1] = 0; up[0] = 0; up[1] = 0;
            finish_run = 0;
            quiet = (m_ph[0] == 0 || m_ph[0] == 3) && (m_ph[1] == 0 || m_ph[1] == 3);
            if (m_run && quiet) begin
                // slave leaves first, master returns first
                if (m_ph[1] == 0 && !want_on(1))      dn[1] = 1;
                else if (m_ph[0] == 0 && !want_on(0)) dn[0] = 1;
                else if (m_ph[0] == 3 && want_on(0))  up[0] = 1;
                else if (m_ph[1] == 3 && want_on(1))  up[1] = 1;
                else                                  finish_run = 1;
            end
            for (int d = 0; d < 2; d++) begin
                case (m_ph[d])
                    0: if (dn[d]) m_ph[d] = 1;
                    1: m_ph[d] = 2;
                    2: m_ph[d] = 3;
                    3: if (up[d]) begin m_ph[d] = 4; m_tm[d] = settle_cycles; end
                    4: if (m_tm[d] == 0) m_ph[d] = 5; else m_tm[d]--;
                    default: m_ph[d] = 0;
                endcase
            end
            m_err = req_valid && (mode_req == 2'b10);
            if (!m_run) begin
                if (m_pv) begin
                    m_run = 1; m_tgm = m_pm; m_tgs = m_ps; m_pv = 0;
                end
            end else if (finish_run) begin
                m_run = 0;
            end
            if (req_valid && mode_req != 2'b10) begin
                m_pv = 1;
                m_pm = mode_req[0];
                m_ps = mode_req[1] && mode_req[0] && xfer_rd;
            end
        end
    end

    function automatic bit e_pwr(input int p);  return p != 3; endfunction
    function automatic bit e_rn(input int p);   return p == 0 || p == 1 || p == 2 || p == 5; endfunction
    function automatic bit e_save(input int p); return p == 2 || p == 3 || p == 4; endfunction
    function automatic bit e_iso(input int p);  return p != 0; endfunction

    // ---------------- per-cycle comparison and order monitors ----------------
    int  iso_rise_at[2];
    int  pwr_rise_at[2];
    bit  p_pwr[2];
    bit  p_iso[2];
    int  both_bad = 0;
    bit  watchdog_hit = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit a_pwr[2], a_iso[2], a_sv[2], a_rn[2];
            cyc++;
            a_pwr[0] = mst_pwr_en; a_iso[0] = mst_iso; a_sv[0] = mst_save; a_rn[0] = mst_restore_n;
            a_pwr[1] = slv_pwr_en; a_iso[1] = slv_iso; a_sv[1] = slv_save; a_rn[1] = slv_restore_n;
            for (int d = 0; d < 2; d++) begin
                chk(a_pwr[d] == e_pwr(m_ph[d]), "R2", "pwr_en vs model", a_pwr[d], e_pwr(m_ph[d]));
                chk(a_rn[d] == e_rn(m_ph[d]), "R2", "restore_n vs model", a_rn[d], e_rn(m_ph[d]));
                chk(a_sv[d] == e_save(m_ph[d]), "R2", "save vs model", a_sv[d], e_save(m_ph[d]));
                chk(a_iso[d] == e_iso(m_ph[d]), "R2", "iso vs model", a_iso[d], e_iso(m_ph[d]));
                if (a_iso[d] && !p_iso[d]) iso_rise_at[d] = cyc;
                if (a_pwr[d] && !p_pwr[d]) pwr_rise_at[d] = cyc;
                if (!a_pwr[d] && p_pwr[d])
                    chk(cyc - iso_rise_at[d] == 2, "R4", "iso-rise to switch-off cycles",
                        cyc - iso_rise_at[d], 2);
                if (!a_iso[d] && p_iso[d])
                    chk(cyc - pwr_rise_at[d] == settle_cycles + 2, "R5",
                        "switch-on to iso-release cycles", cyc - pwr_rise_at[d], settle_cycles + 2);
                p_pwr[d] = a_pwr[d];
                p_iso[d] = a_iso[d];
            end
            chk(busy == (m_run || m_pv), "R8", "busy vs model", busy, m_run || m_pv);
            chk(req_err == m_err, "R9", "req_err vs model", req_err, m_err);
            if (slv_pwr_en && !mst_pwr_en) both_bad++;
        end else begin
            p_pwr[0] = 0; p_pwr[1] = 0; p_iso[0] = 1; p_iso[1] = 1;
            iso_rise_at[0] = 0; iso_rise_at[1] = 0;
            pwr_rise_at[0] = 0; pwr_rise_at[1] = 0;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [1:0] code, input logic rd);
        @(negedge clk);
        req_valid = 1'b1; mode_req = code; xfer_rd = rd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic expect_dom(input string req, input bit m_on, input bit s_on);
        chk(mst_pwr_en == m_on && mst_iso == !m_on && mst_restore_n == m_on && mst_save == !m_on,
            req, "master steady state", {mst_pwr_en, mst_iso, mst_restore_n, mst_save},
            {m_on, !m_on, m_on, !m_on});
        chk(slv_pwr_en == s_on && slv_iso == !s_on && slv_restore_n == s_on && slv_save == !s_on,
            req, "slave steady state", {slv_pwr_en, slv_iso, slv_restore_n, slv_save},
            {s_on, !s_on, s_on, !s_on});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset held
        expect_dom("R1", 0, 0);
        chk(busy == 0 && req_err == 0, "R1", "busy/err in reset", {busy, req_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_dom("R1", 0, 0);

        // R2: full on for a read
        send(2'b11, 1'b1);
        chk(busy == 1, "R8", "busy after request", busy, 1);
        wait_idle();
        expect_dom("R2", 1, 1);
        chk(busy == 0, "R8", "busy low in steady state", busy, 0);

        // R3: write-only downgrade to partial
        send(2'b11, 1'b0);
        wait_idle();
        expect_dom("R3", 1, 0);

        // R8: same-mode request changes nothing
        send(2'b01, 1'b0);
        wait_idle();
        expect_dom("R8", 1, 0);

        // R6: full on then full off, slave leaves first
        send(2'b11, 1'b1);
        wait_idle();
        send(2'b00, 1'b0);
        wait_idle();
        expect_dom("R2", 0, 0);

        // R9: illegal code rejected, nothing moves
        send(2'b10, 1'b1);
        chk(req_err == 1, "R9", "err pulse", req_err, 1);
        @(negedge clk);
        chk(req_err == 0, "R9", "err single cycle", req_err, 0);
        chk(busy == 0, "R9", "nothing queued", busy, 0);
        expect_dom("R9", 0, 0);

        // R7: requests during a running sequence, latest wins
        send(2'b11, 1'b1);
        repeat (2) @(negedge clk);
        send(2'b00, 1'b0);
        send(2'b10, 1'b1);
        send(2'b01, 1'b1);
        wait_idle();
        expect_dom("R7", 1, 0);

        // R5: zero settle count
        settle_cycles = 8'd0;
        send(2'b11, 1'b1);
        wait_idle();
        expect_dom("R5", 1, 1);
        send(2'b00, 1'b0);
        wait_idle();
        settle_cycles = 8'd7;
        send(2'b11, 1'b1);
        wait_idle();
        expect_dom("R5", 1, 1);

        chk(both_bad == 0, "R6", "cycles slave on with master off", both_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        watchdog_hit = 1;
        chk(0, "R8", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule